// File: doc/BRIEF.md
# Remapping Line-Select Decoder

This block takes the place of the fixed index decoder in a direct-mapped cache. Each physical cache line owns a small programmable register. The register holds a valid bit, a context tag and an extended logical index. A lookup presents a context tag and an index that is k bits wider than the physical line count needs. Every register compares itself against the request in parallel. The block then drives a word-line select that has at most one bit set. When no register matches, it raises an early index-miss flag before any tag array is read.

The line count does not have to be a power of two. Several address mappings can share the same register set, because the context tag keeps them apart. When the cache replaces a line, the replacement logic reprograms that line's register through a write port. The same port can also invalidate a register on eviction. The lookup is registered, so the result appears one clock after the request. A write and a lookup that fall in the same cycle see the register contents as they were before the write.

Top module: `remap_decoder`

## Requirements
- R1: After reset every register is invalid, so any lookup made before the first write returns an index miss with an all-zero select.
- R2: A lookup presented in cycle t with `lk_valid` high sets `rsp_valid` in cycle t+1. It also sets the single `rsp_sel` bit of the line whose register is valid and whose stored context and stored index both equal the request, and holds `rsp_miss` low.
- R3: A register whose stored context differs from `lk_ctx` never matches, even when its stored index is equal.
- R4: A register whose stored index differs from `lk_index` in any bit, including the upper k extension bits, never matches.
- R5: When `lk_valid` is high and no register matches, `rsp_miss` is 1 and `rsp_sel` is all zero one cycle later.
- R6: `wr_en`=1 with `wr_evict`=0 loads `wr_ctx` and `wr_index` into the register of line `wr_line` and marks it valid. Lookups from the next cycle on see the new contents.
- R7: A lookup presented in the same cycle as a write to any line returns the result from the contents as they were before the write.
- R8: `wr_en`=1 with `wr_evict`=1 marks the register of line `wr_line` invalid. Later lookups that would have matched it return a miss.
- R9: A cycle with `lk_valid` low produces `rsp_valid`=0, `rsp_sel`=0 and `rsp_miss`=0 in the next cycle.
- R10: A write whose `wr_line` is not below the line count (e.g. 12 to 15 with the default 12 lines) changes no register.
- R11: `rsp_sel` never has more than one bit set.
- R12: Two lines that hold the same index under different contexts both stay resident. Each is selected only by its own context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ctx | input | CTX_W | Context tag of the lookup |
| lk_index | input | IDX_W | Extended logical index of the lookup |
| wr_en | input | 1 | Register write strobe |
| wr_evict | input | 1 | 1: invalidate the line; 0: load it |
| wr_line | input | $clog2(LINES) | Physical line to reprogram |
| wr_ctx | input | CTX_W | Context tag to store |
| wr_index | input | IDX_W | Logical index to store |
| rsp_valid | output | 1 | Registered lookup result present |
| rsp_sel | output | LINES | Word-line select, bit i = line i |
| rsp_miss | output | 1 | Index miss: no register matched |

## Verification
The lookup compare and the register reprogram can fall in the same clock edge, and they may target the very line being looked up. The bench provokes this with directed cases: loading a line while looking up its new pair, and evicting a line while looking up its old pair. The random phase also writes a line on most cycles while lookups run against it. Each same-cycle result is judged against a reference copy of the register contents taken before that cycle's write is applied. So a load must still miss and an eviction must still hit in that cycle, and the next cycle must show the change.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_EVICT = 2'd2
    } wr_op_e;

    function automatic wr_op_e decode_op(input logic en, input logic evict);
        if (!en)
            return OP_IDLE;
        else if (evict)
            return OP_EVICT;
        else
            return OP_LOAD;
    endfunction

endpackage

// File: rtl/remap_line_entry.sv
module remap_line_entry
    import remap_pkg::*;
#(
    parameter int CTX_W   = 2,
    parameter int IDX_W   = 14,
    parameter int LINE_W  = 4,
    parameter int LINE_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_op_e            wr_op,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              match
);

    typedef struct packed {
        logic             valid;
        logic [CTX_W-1:0] ctx;
        logic [IDX_W-1:0] idx;
    } entry_t;

    entry_t entry_q;
    logic   targeted;

    assign targeted = (wr_line == LINE_W'(LINE_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '0;
        end else if (targeted) begin
            case (wr_op)
                OP_LOAD:  entry_q <= '{valid: 1'b1, ctx: wr_ctx, idx: wr_index};
                OP_EVICT: entry_q.valid <= 1'b0;
                default:  entry_q <= entry_q;
            endcase
        end
    end

    // Compare on the pre-write contents: a same-cycle write lands at the edge.
    assign match = entry_q.valid
                 && (entry_q.ctx == lk_ctx)
                 && (entry_q.idx == lk_index);

    // R6: a load leaves the register valid with the written fields
    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_LOAD && targeted) |=>
            (entry_q.valid && entry_q.ctx == $past(wr_ctx) && entry_q.idx == $past(wr_index)));

    // R8: an eviction leaves the register unable to match
    assert_evict_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_EVICT && targeted) |=> !match);

    // R10: untargeted registers keep their contents
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !targeted |=> $stable(entry_q));

endmodule

// File: rtl/remap_resp_stage.sv
module remap_resp_stage #(
    parameter int LINES = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [LINES-1:0] match,
    output logic             rsp_valid,
    output logic [LINES-1:0] rsp_sel,
    output logic             rsp_miss
);

    logic any_match;
    assign any_match = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_sel   <= '0;
            rsp_miss  <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_sel   <= lk_valid ? match : '0;
            rsp_miss  <= lk_valid && !any_match;
        end
    end

    // R11: at most one word line is driven
    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_sel));

    // R5: a miss never comes with a select
    assert_miss_nosel_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_sel == '0));

    // R2: a valid non-miss response selects exactly one line
    assert_hit_one_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_miss) |-> ($countones(rsp_sel) == 1));

endmodule

// File: rtl/remap_decoder.sv
module remap_decoder
    import remap_pkg::*;
#(
    parameter int LINES = 12,
    parameter int IDX_W = 14,
    parameter int CTX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lk_valid,
    input  logic [CTX_W-1:0]         lk_ctx,
    input  logic [IDX_W-1:0]         lk_index,
    input  logic                     wr_en,
    input  logic                     wr_evict,
    input  logic [$clog2(LINES)-1:0] wr_line,
    input  logic [CTX_W-1:0]         wr_ctx,
    input  logic [IDX_W-1:0]         wr_index,
    output logic                     rsp_valid,
    output logic [LINES-1:0]         rsp_sel,
    output logic                     rsp_miss
);

    localparam int LINE_W = $clog2(LINES);

    wr_op_e           wr_op;
    logic [LINES-1:0] match;

    assign wr_op = decode_op(wr_en, wr_evict);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        remap_line_entry #(
            .CTX_W  (CTX_W),
            .IDX_W  (IDX_W),
            .LINE_W (LINE_W),
            .LINE_ID(i)
        ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .wr_op   (wr_op),
            .wr_line (wr_line),
            .wr_ctx  (wr_ctx),
            .wr_index(wr_index),
            .lk_ctx  (lk_ctx),
            .lk_index(lk_index),
            .match   (match[i])
        );
    end

    remap_resp_stage #(.LINES(LINES)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .match    (match),
        .rsp_valid(rsp_valid),
        .rsp_sel  (rsp_sel),
        .rsp_miss (rsp_miss)
    );

    // R2: each request yields a response one cycle later
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R9: an idle cycle yields a quiet response
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && rsp_sel == '0 && !rsp_miss));

endmodule

// File: tb/remap_decoder_tb.sv
`timescale 1ns/100ps
module remap_decoder_tb;

    localparam int LINES  = 12;
    localparam int IDX_W  = 14;
    localparam int CTX_W  = 2;
    localparam int LINE_W = $clog2(LINES);

    logic              clk = 1'b0;
    logic              rst;
    logic              lk_valid;
    logic [CTX_W-1:0]  lk_ctx;
    logic [IDX_W-1:0]  lk_index;
    logic              wr_en;
    logic              wr_evict;
    logic [LINE_W-1:0] wr_line;
    logic [CTX_W-1:0]  wr_ctx;
    logic [IDX_W-1:0]  wr_index;
    logic              rsp_valid;
    logic [LINES-1:0]  rsp_sel;
    logic              rsp_miss;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic             m_valid [LINES];
    logic [CTX_W-1:0] m_ctx   [LINES];
    logic [IDX_W-1:0] m_idx   [LINES];

    always #2.5 clk = ~clk;

    remap_decoder #(.LINES(LINES), .IDX_W(IDX_W), .CTX_W(CTX_W)) u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ctx(lk_ctx), .lk_index(lk_index),
        .wr_en(wr_en), .wr_evict(wr_evict), .wr_line(wr_line),
        .wr_ctx(wr_ctx), .wr_index(wr_index),
        .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_miss(rsp_miss)
    );

    function automatic logic [LINES-1:0] expect_sel(input logic [CTX_W-1:0] c,
                                                     input logic [IDX_W-1:0] x);
        logic [LINES-1:0] s = '0;
        for (int i = 0; i < LINES; i++)
            if (m_valid[i] && m_ctx[i] == c && m_idx[i] == x) s[i] = 1'b1;
        return s;
    endfunction

    function automatic bit pair_used(input logic [CTX_W-1:0] c,
                                     input logic [IDX_W-1:0] x, input int skip);
        for (int i = 0; i < LINES; i++)
            if (i != skip && m_valid[i] && m_ctx[i] == c && m_idx[i] == x) return 1;
        return 0;
    endfunction

    // One cycle: drive at negedge, sample 1 ns after the next posedge.
    task automatic step(input logic lv, input logic [CTX_W-1:0] lc,
                        input logic [IDX_W-1:0] li, input logic we, input logic ev,
                        input logic [LINE_W-1:0] wl, input logic [CTX_W-1:0] wc,
                        input logic [IDX_W-1:0] wi, input string tag);
        logic [LINES-1:0] es;
        logic em, evl;
        lk_valid = lv; lk_ctx = lc; lk_index = li;
        wr_en = we; wr_evict = ev; wr_line = wl; wr_ctx = wc; wr_index = wi;
        es  = lv ? expect_sel(lc, li) : '0;
        em  = lv && (es == '0);
        evl = lv;
        @(posedge clk);
        #1;
        tests++;
        if (rsp_valid !== evl || rsp_sel !== es || rsp_miss !== em) begin
            fails++;
            $display("FAIL %s: valid/sel/miss actual %b/%b/%b expected %b/%b/%b",
                     tag, rsp_valid, rsp_sel, rsp_miss, evl, es, em);
        end
        if (we && int'(wl) < LINES) begin
            m_valid[wl] = !ev;
            if (!ev) begin
                m_ctx[wl] = wc;
                m_idx[wl] = wi;
            end
        end
        @(negedge clk);
    endtask

    task automatic look(input logic [CTX_W-1:0] c, input logic [IDX_W-1:0] x,
                        input string tag);
        step(1'b1, c, x, 1'b0, 1'b0, '0, '0, '0, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 1'b0; m_ctx[i] = '0; m_idx[i] = '0;
        end
        rst = 1'b1;
        lk_valid = 0; lk_ctx = '0; lk_index = '0;
        wr_en = 0; wr_evict = 0; wr_line = '0; wr_ctx = '0; wr_index = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        tests++;
        if (rsp_valid !== 1'b0 || rsp_sel !== '0 || rsp_miss !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset outputs %b/%b/%b expected 0/0/0", rsp_valid, rsp_sel, rsp_miss);
        end
        rst = 1'b0;

        look(2'd0, 14'd0, "R1 empty lookup");
        look(2'd1, 14'h005, "R1 empty lookup");
        // R7: load line 0 while looking its new pair up: old (miss)
        step(1'b1, 2'd1, 14'h005, 1'b1, 1'b0, 4'd0, 2'd1, 14'h005, "R7 load same cycle");
        look(2'd1, 14'h005, "R6 R2 hit after load");
        look(2'd2, 14'h005, "R3 context mismatch");
        look(2'd1, 14'h2005, "R4 extension bit differs");
        look(2'd1, 14'h004, "R4 low bit differs");
        step(1'b0, 2'd1, 14'h005, 1'b0, 1'b0, '0, '0, '0, "R9 idle");
        // R12: same index, other context, last line
        step(1'b0, '0, '0, 1'b1, 1'b0, 4'd11, 2'd2, 14'h005, "R9 idle with write");
        look(2'd2, 14'h005, "R12 second context");
        look(2'd1, 14'h005, "R12 first context kept");
        // R10: out-of-range write must not land anywhere
        step(1'b0, '0, '0, 1'b1, 1'b0, 4'd13, 2'd3, 14'h3FFF, "R10 idle");
        look(2'd3, 14'h3FFF, "R10 out-of-range write");
        step(1'b0, '0, '0, 1'b1, 1'b1, 4'd15, '0, '0, "R10 idle");
        look(2'd2, 14'h005, "R10 out-of-range evict");
        // R7: evict line 0 while looking it up: still hit this cycle
        step(1'b1, 2'd1, 14'h005, 1'b1, 1'b1, 4'd0, '0, '0, "R7 evict same cycle");
        look(2'd1, 14'h005, "R8 miss after evict");
        look(2'd2, 14'h005, "R8 other line unaffected");

        for (int n = 0; n < 4000; n++) begin
            logic [CTX_W-1:0]  lc = CTX_W'($urandom % 4);
            logic [IDX_W-1:0]  li = IDX_W'((($urandom % 6) << 10) | ($urandom % 4));
            logic [CTX_W-1:0]  wc = CTX_W'($urandom % 4);
            logic [IDX_W-1:0]  wi = IDX_W'((($urandom % 6) << 10) | ($urandom % 4));
            logic [LINE_W-1:0] wl = LINE_W'($urandom % 16);
            logic lv = ($urandom % 8) != 0;
            logic we = ($urandom % 3) != 0;
            logic ev = ($urandom % 5) == 0;
            logic [LINES-1:0] es;
            string tag;
            if (we && !ev && int'(wl) < LINES && pair_used(wc, wi, int'(wl))) ev = 1'b1;
            es = expect_sel(lc, li);
            if (!lv) tag = "R9 random idle";
            else if (we && int'(wl) < LINES && es[wl]) tag = "R7 random overlap";
            else if (we && int'(wl) >= LINES) tag = "R10 random";
            else if (es != '0) tag = "R2 random hit";
            else tag = "R5 random miss";
            step(lv, lc, li, we, ev, wl, wc, wi, tag);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule